// File: doc/BRIEF.md
# Clock Synthesizer Scan-Chain Reconfiguration Controller

This block reprograms the divider and loop settings of an on-chip clock synthesizer while the chip is running. A host presents a complete new setting word on a parallel input and pulses a start command. The controller captures that word, then sends it bit by bit into the synthesizer's serial configuration chain. After the final bit it raises a commit strobe for one scan step, waits for the chain to report that the new settings are live, and then gives a one-cycle completion pulse.

The setting word holds the pre-scale divider, the feedback divider, five output dividers (each split into a high-count and a low-count half), and three small loop codes: filter resistance, filter capacitance and pump current. The scan chain keeps two copies of the settings. One is the shift copy, which fills while bits arrive. The other is the live copy, which changes only on the commit strobe, so the synthesizer never runs with a half-loaded setting. The chain model included here stands in for that shift and live storage. It echoes the bits that leave its far end, so the host can read back the previously loaded setting while the new one goes in.

The controller runs from a fast system clock. It advances the chain only on a scan-step enable that fires once every `SCAN_DIV` clocks. With the default of 2 and a 200 MHz system clock, the effective scan rate stays at 100 MHz, which is the ceiling for the chain.

Top module: `pllscan_reconfig`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `scan_ena` and `cfg_update` are 0 and `live_cfg` is all zeros.
- R2: The chain length is 3·3 + 7·2·9 = 135 bits with default parameters. `cfg_in` is laid out from bit 0 upward as: filter resistance, filter capacitance, pump current, then pre-scale, feedback, and output dividers 0 to 4 (each divider low half then high half). `scan_data` presents `cfg_in` bit 0 first and bit 134 last.
- R3: `scan_step` pulses once every `SCAN_DIV` (default 2) clocks. Exactly 135 shift steps occur per reconfiguration, each one a cycle where `scan_ena` and `scan_step` are both high. With `scan_ena` low, `scan_data_out` does not change.
- R4: `live_cfg` does not change while `scan_ena` is high. After a reconfiguration completes it equals the `cfg_in` captured at start.
- R5: `cfg_update` rises only after the last shift step. It stays high for exactly one scan step (`SCAN_DIV` clocks) and is never high together with `scan_ena`.
- R6: `done` is high for exactly one clock per reconfiguration. In that clock `busy` is high, and in the next clock `busy` is 0.
- R7: A `start`, or a change on `cfg_in`, while `busy` is high (including the `done` cycle) has no effect. No new sequence begins, and `live_cfg` ends equal to the word captured at the accepted start.
- R8: On shift step k (k = 0 to 134), `scan_data_out` equals bit k of the previously committed setting (all zeros before the first load).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to load `cfg_in` into the chain |
| cfg_in | input | 135 | New setting word (field layout in R2) |
| busy | output | 1 | High from accepted start until the done cycle inclusive |
| done | output | 1 | One-clock completion pulse |
| scan_step | output | 1 | Scan-step enable, once per `SCAN_DIV` clocks |
| scan_ena | output | 1 | Chain shift enable |
| scan_data | output | 1 | Serial data into the chain |
| cfg_update | output | 1 | Commit strobe from shift copy to live copy |
| scan_data_out | output | 1 | Serial bit leaving the far end of the chain |
| live_cfg | output | 135 | Live configuration bits of the chain model |

## Verification
Two events can fall in the same clock: a new `start` and the `done` pulse that ends the previous sequence. The bench provokes this by watching for `done` and raising `start`, with a different `cfg_in`, in that same clock. It also raises `start` repeatedly in the middle of a shift. It judges the result at the ports. `busy` must fall on the next clock and stay low, and `live_cfg` must keep the word captured at the accepted start. A scoreboard follows every shift step and compares both the bit sent into the chain and the bit read back out of it.

// File: rtl/pllscan_pkg.sv
package pllscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_UPDATE = 2'd2,
    ST_WAIT   = 2'd3
  } scan_state_e;

  // Chain length from field widths: three loop codes plus counters with two halves each.
  function automatic int chain_bits(input int half_w, input int num_post,
                                    input int r_w, input int c_w, input int cp_w);
    return r_w + c_w + cp_w + (2 + num_post) * 2 * half_w;
  endfunction

endpackage

// File: rtl/pllscan_rst_sync.sv
module pllscan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pllscan_ctrl.sv
module pllscan_ctrl
  import pllscan_pkg::*;
#(
  parameter int CHAIN_LEN = 135,
  parameter int SCAN_DIV  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CHAIN_LEN-1:0] cfg_in,
  input  logic                 scan_done,
  output logic                 busy,
  output logic                 done,
  output logic                 scan_step,
  output logic                 scan_ena,
  output logic                 scan_data,
  output logic                 cfg_update
);

  localparam int CNT_W = $clog2(CHAIN_LEN + 1);
  localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

  logic tick;

  // Scan-step enable: a divider when SCAN_DIV > 1, otherwise every clock.
  generate
    if (SCAN_DIV > 1) begin : g_div
      logic [DIV_W-1:0] div_q, div_d;
      logic             div_wrap;
      assign div_wrap = (div_q == DIV_W'(SCAN_DIV - 1));
      always_comb begin
        div_d = div_wrap ? '0 : div_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q <= '0;
        end else begin
          div_q <= div_d;
        end
      end
      assign tick = div_wrap;
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  scan_state_e          state_q, state_d;
  logic [CHAIN_LEN-1:0] stage_q, stage_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 done_c;

  always_comb begin
    state_d = state_q;
    stage_d = stage_q;
    cnt_d   = cnt_q;
    done_c  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          stage_d = cfg_in;
          cnt_d   = CNT_W'(CHAIN_LEN - 1);
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          stage_d = {1'b0, stage_q[CHAIN_LEN-1:1]};
          cnt_d   = cnt_q - 1'b1;
          if (cnt_q == '0) begin
            state_d = ST_UPDATE;
          end
        end
      end
      ST_UPDATE: begin
        if (tick) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tick && scan_done) begin
          state_d = ST_IDLE;
          done_c  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_c;
  assign scan_step  = tick;
  assign scan_ena   = (state_q == ST_SHIFT);
  assign scan_data  = stage_q[0];
  assign cfg_update = (state_q == ST_UPDATE);

  // R5: commit strobe never overlaps shifting.
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_ena && cfg_update));

  // R5: commit strobe holds until the scan step completes.
  a_r5_hold_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_update && !scan_step) |=> cfg_update);

  // R5: commit follows the shift phase directly.
  a_r5_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_update) |-> $past(scan_ena));

  // R6: busy drops right after done.
  a_r6_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R7: once busy, nothing but done ends the sequence.
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/pllscan_chain_model.sv
module pllscan_chain_model #(
  parameter int CHAIN_LEN = 135
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 shift_en,
  input  logic                 sin,
  input  logic                 update,
  output logic                 sout,
  output logic [CHAIN_LEN-1:0] live,
  output logic                 done_o
);

  logic [CHAIN_LEN-1:0] scan_q, scan_d;
  logic [CHAIN_LEN-1:0] live_q, live_d;
  logic                 done_q, done_d;

  always_comb begin
    scan_d = scan_q;
    live_d = live_q;
    done_d = done_q;
    if (step) begin
      if (shift_en) begin
        scan_d = {sin, scan_q[CHAIN_LEN-1:1]};
      end
      if (update) begin
        live_d = scan_q;
      end
      done_d = update;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
      live_q <= '0;
      done_q <= 1'b0;
    end else begin
      scan_q <= scan_d;
      live_q <= live_d;
      done_q <= done_d;
    end
  end

  assign sout   = scan_q[0];
  assign live   = live_q;
  assign done_o = done_q;

  // R4: live bits are frozen while shifting.
  a_r4_live_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> $stable(live_q));

  // R3: the shift copy moves only on an enabled step.
  a_r3_shift_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && shift_en) |=> $stable(scan_q));

  // R6: completion is reported only after a commit.
  a_r6_done_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(update));

endmodule

// File: rtl/pllscan_reconfig.sv
module pllscan_reconfig
  import pllscan_pkg::*;
#(
  parameter  int DIV_HALF_W = 9,
  parameter  int NUM_POST   = 5,
  parameter  int LF_R_W     = 3,
  parameter  int LF_C_W     = 3,
  parameter  int CP_W       = 3,
  parameter  int SCAN_DIV   = 2,
  localparam int CHAIN_LEN  = chain_bits(DIV_HALF_W, NUM_POST, LF_R_W, LF_C_W, CP_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CHAIN_LEN-1:0] cfg_in,
  output logic                 busy,
  output logic                 done,
  output logic                 scan_step,
  output logic                 scan_ena,
  output logic                 scan_data,
  output logic                 cfg_update,
  output logic                 scan_data_out,
  output logic [CHAIN_LEN-1:0] live_cfg
);

  logic rst_n_int;
  logic chain_done;

  pllscan_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  pllscan_ctrl #(
    .CHAIN_LEN (CHAIN_LEN),
    .SCAN_DIV  (SCAN_DIV)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (start),
    .cfg_in     (cfg_in),
    .scan_done  (chain_done),
    .busy       (busy),
    .done       (done),
    .scan_step  (scan_step),
    .scan_ena   (scan_ena),
    .scan_data  (scan_data),
    .cfg_update (cfg_update)
  );

  pllscan_chain_model #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .step     (scan_step),
    .shift_en (scan_ena),
    .sin      (scan_data),
    .update   (cfg_update),
    .sout     (scan_data_out),
    .live     (live_cfg),
    .done_o   (chain_done)
  );

endmodule

// File: tb/pllscan_reconfig_bench.sv
module pllscan_reconfig_bench;

  localparam int LEN  = 135;
  localparam int STEP = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [LEN-1:0] cfg_in;
  logic           busy, done, scan_step, scan_ena, scan_data, cfg_update, scan_data_out;
  logic [LEN-1:0] live_cfg;

  always #2.5 clk = ~clk;

  pllscan_reconfig u_pllscan_reconfig (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
    .busy(busy), .done(done), .scan_step(scan_step), .scan_ena(scan_ena),
    .scan_data(scan_data), .cfg_update(cfg_update),
    .scan_data_out(scan_data_out), .live_cfg(live_cfg)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit mon_on = 0;

  bit exp_sd_q[$];
  bit exp_rb_q[$];
  int shifts_seen, upd_cycles, done_cycles, cyc, last_step;
  bit gap_bad;
  logic [LEN-1:0] live_hold;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LEN-1:0] act, input logic [LEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: scoreboard pops one expected pair per shift step.
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (scan_step) begin
        if (last_step >= 0 && busy && (cyc - last_step) != STEP) gap_bad = 1;
        last_step = cyc;
      end
      if (scan_ena && scan_step) begin
        shifts_seen++;
        if (exp_sd_q.size() == 0) begin
          check(0, "R2", "unexpected shift step", 1, 0);
        end else begin
          bit esd, erb;
          esd = exp_sd_q.pop_front();
          erb = exp_rb_q.pop_front();
          check(scan_data == esd, "R2", "scan_data bit", scan_data, esd);
          check(scan_data_out == erb, "R8", "readback bit", scan_data_out, erb);
        end
      end
      if (scan_ena) check(live_cfg == live_hold, "R4", "live changed during shift", live_cfg, live_hold);
      if (cfg_update) begin
        if (upd_cycles == 0) check(live_cfg == live_hold, "R4", "live before commit", live_cfg, live_hold);
        upd_cycles++;
      end
      if (done) begin
        done_cycles++;
        check(busy == 1'b1, "R6", "busy in done cycle", busy, 1);
      end
    end
  end

  // Driver: pushes expectations and runs one reconfiguration.
  task automatic run_load(input logic [LEN-1:0] nv, input logic [LEN-1:0] prev,
                          input bit noisy, input bit poke_done);
    int n;
    for (int i = 0; i < LEN; i++) begin
      exp_sd_q.push_back(nv[i]);
      exp_rb_q.push_back(prev[i]);
    end
    shifts_seen = 0; upd_cycles = 0; done_cycles = 0; gap_bad = 0; last_step = -1;
    live_hold = prev;
    @(negedge clk);
    start = 1'b1; cfg_in = nv;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      if (noisy && n >= 20 && n < 40) begin
        start = 1'b1; cfg_in = ~nv;            // R7 stimulus mid-shift
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    check(n < 2000, "R6", "done never seen", n, 2000);
    if (poke_done) begin
      start = 1'b1; cfg_in = ~nv;              // R7 start in the done cycle
    end
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R6", "busy after done", busy, 0);
    check(shifts_seen == LEN, "R3", "shift step count", shifts_seen, LEN);
    check(!gap_bad, "R3", "scan step spacing", gap_bad, 0);
    check(upd_cycles == STEP, "R5", "commit strobe width", upd_cycles, STEP);
    check(done_cycles == 1, "R6", "done pulse width", done_cycles, 1);
    check(exp_sd_q.size() == 0, "R2", "bits left unsent", exp_sd_q.size(), 0);
    check(live_cfg == nv, "R4", "live after commit", live_cfg, nv);
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R7", "stray start began a sequence", busy, 0);
    check(live_cfg == nv, "R7", "live kept accepted word", live_cfg, nv);
    check(scan_data_out == nv[0], "R3", "chain idle output", scan_data_out, nv[0]);
    exp_sd_q.delete();
    exp_rb_q.delete();
  endtask

  function automatic logic [LEN-1:0] build(input int s);
    logic [LEN-1:0] v;
    v[2:0] = 3'(s); v[5:3] = 3'(s + 3); v[8:6] = 3'(s + 5);
    for (int k = 0; k < 7; k++) v[9 + 18*k +: 18] = 18'((s * 7919 + k * 1031) ^ (k << 12));
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R6", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [LEN-1:0] a, b, c, d;
    rst_n = 1'b0; start = 1'b0; cfg_in = '0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && scan_ena == 0 && cfg_update == 0, "R1", "control outs in reset",
          {busy, done, scan_ena, cfg_update}, 0);
    check(live_cfg == '0, "R1", "live in reset", live_cfg, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy == 0 && live_cfg == '0, "R1", "state after reset", {busy, live_cfg}, 0);
    mon_on = 1;
    a = build(11);
    b = build(23);
    c = '1;
    d = {LEN{1'b0}} | {(LEN/2){2'b10}};
    run_load(a, '0, 0, 0);
    run_load(b, a, 1, 1);
    run_load(c, b, 0, 1);
    run_load(d, c, 1, 0);
    finish_run();
  end

endmodule